// File: doc/BRIEF.md
# Prioritised Edge Interrupt Controller

This block gathers sixteen maskable interrupt lines and one non-maskable line and turns them into a single 6-bit interrupt code for a processor. Every input is edge-sensitive. A rising transition counts as a new interrupt event. A maskable event is recorded in an active-low status register. It is forwarded only when the source's programmed 3-bit level exceeds a global numeric threshold. The non-maskable line skips the status, level and threshold logic and always yields a fixed code. When any line drops back to zero, the block emits code 0, which tells the processor the interrupt has been withdrawn.

Software programs the block through a byte-wide register port. Each write changes exactly one byte lane. Reads are combinational. The sixteen source bits, from bit 0 upwards, carry: external lines 1 to 7, DMA channels 3, 2, 1 and 0, serial channels 0 and 1, and timers 0, 1 and 2. The code for source s is 16+s, so this order is visible to the processor. Only one code is presented at a time, and no event is queued.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A cycle with `rst` high sets the status register to 0x0000FFFF, the threshold and all four level registers to 0, `code_o` to 0 and `code_vld_o` to 0.
- R2: Registers are addressed by `bus_addr_i[4:2]`: word 0 is status (bits 15:0, upper 16 bits read 0), word 1 is the 32-bit threshold, and words 4 to 7 (offsets 16, 20, 24, 28) are level registers. Level word 4+k holds sources 4k to 4k+3. `bus_rdata_o` returns byte lane `bus_addr_i[1:0]` (lane b is bits 8b+7..8b). Reads of words 2 and 3 return 0, and writes to them change nothing.
- R3: A write with `bus_wr_i` high changes only the addressed byte lane of the addressed register. Writes to status lanes 2 and 3 are dropped.
- R4: A rising edge on source s clears status bit s to 0, and this clear overrides a same-cycle write to that bit. Software may write a status bit back to 1.
- R5: Source s has its level in bits (s mod 4)*8+2..(s mod 4)*8 of its level word. A rising edge on source s whose level is strictly greater than the threshold (unsigned 32-bit compare) gives `code_vld_o`=1 and `code_o`=16+s in the cycle after the clock edge that samples the rise. `code_o` holds its value until the next event.
- R6: A rising edge on a source whose level is equal to or below the threshold produces no event.
- R7: A rising edge on `nmi_i` gives `code_o`=32 with `code_vld_o`=1 regardless of threshold and levels, and it takes precedence over any source event in the same cycle.
- R8: When several qualifying sources rise in the same cycle, the lowest-numbered one gives the code.
- R9: A falling edge on any source or on `nmi_i`, in a cycle with no other event, gives `code_vld_o`=1 with `code_o`=0.
- R10: `code_vld_o` is high for one cycle per event. A line held high produces no further events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 16 | Maskable interrupt lines, source 0 in bit 0 |
| nmi_i | input | 1 | Non-maskable interrupt line |
| bus_wr_i | input | 1 | Byte write strobe |
| bus_addr_i | input | 5 | Byte address within the 32-byte bank |
| bus_wdata_i | input | 8 | Write byte |
| bus_rdata_o | output | 8 | Read byte for `bus_addr_i` |
| code_o | output | 6 | Interrupt code: 0 cleared, 16..31 source, 32 non-maskable |
| code_vld_o | output | 1 | One-cycle event strobe |

## Verification
The hardest situations to reach are the ones where several things meet in one cycle: a source rising while software writes its status byte, or the non-maskable line rising together with qualifying sources. Also hard is a level that sits exactly on the threshold. Directed sequences program the threshold and one level to equal values and then to differ by one. They raise several sources together with the non-maskable line, and they issue a status write in the same cycle as a rise. A seeded random phase then mixes toggling lines with byte writes whose threshold values are kept small, so that gating decisions go both ways. Every cycle is compared against a bench reference model.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int unsigned SRC_N      = 16;
    localparam int unsigned LVL_W      = 3;
    localparam int unsigned CODE_W     = 6;
    localparam int unsigned ADDR_W     = 5;
    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned WORD_W     = 32;
    localparam int unsigned NLVL       = SRC_N / 4;
    localparam int unsigned STAT_BYTES = SRC_N / 8;

    // word indices inside the bank (address bits 4:2)
    localparam logic [2:0] W_STAT = 3'd0;
    localparam logic [2:0] W_MASK = 3'd1;

    localparam logic [CODE_W-1:0] CODE_CLEAR = 6'd0;
    localparam logic [CODE_W-1:0] CODE_NMI   = 6'd32;
    localparam logic [1:0]        CODE_SRC_HI = 2'b01;

    typedef enum logic [1:0] {
        EV_NONE,
        EV_NMI,
        EV_SRC,
        EV_CLR
    } ev_kind_e;

    typedef struct packed {
        ev_kind_e   kind;
        logic [3:0] src;
    } irq_evt_t;

    function automatic logic [CODE_W-1:0] code_of(irq_evt_t ev);
        logic [CODE_W-1:0] c;
        case (ev.kind)
            EV_NMI:  c = CODE_NMI;
            EV_SRC:  c = {CODE_SRC_HI, ev.src};
            default: c = CODE_CLEAR;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/irqc_edge.sv
module irqc_edge #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= d_i;
    end

    assign rise_o = d_i & ~prev_q;
    assign fall_o = ~d_i & prev_q;

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en_i,
    input  logic [ADDR_W-1:0]            addr_i,
    input  logic [BYTE_W-1:0]            wdata_i,
    output logic [BYTE_W-1:0]            rdata_o,
    input  logic [SRC_N-1:0]             rise_i,
    output logic [WORD_W-1:0]            mask_o,
    output logic [SRC_N-1:0][LVL_W-1:0]  lvl_o
);
    logic [2:0]                   word;
    logic [1:0]                   lane;
    logic [4:0]                   lane_bit;
    logic [SRC_N-1:0]             stat_q, stat_d;
    logic [WORD_W-1:0]            mask_q;
    logic [NLVL-1:0][WORD_W-1:0]  lvl_q;
    logic [WORD_W-1:0]            word_val;
    logic                         is_lvl;

    assign word     = addr_i[4:2];
    assign lane     = addr_i[1:0];
    assign lane_bit = {lane, 3'b000};
    assign is_lvl   = word[2];

    always_comb begin
        stat_d = stat_q;
        if (wr_en_i && word == W_STAT) begin
            for (int b = 0; b < int'(STAT_BYTES); b++) begin
                if (lane == 2'(b)) stat_d[b*8 +: 8] = wdata_i;
            end
        end
        stat_d = stat_d & ~rise_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '1;
            mask_q <= '0;
            lvl_q  <= '0;
        end else begin
            stat_q <= stat_d;
            if (wr_en_i && word == W_MASK)
                mask_q[lane_bit +: 8] <= wdata_i;
            if (wr_en_i && is_lvl)
                lvl_q[word[1:0]][lane_bit +: 8] <= wdata_i;
        end
    end

    always_comb begin
        word_val = '0;
        if (word == W_STAT)      word_val = WORD_W'(stat_q);
        else if (word == W_MASK) word_val = mask_q;
        else if (is_lvl)         word_val = lvl_q[word[1:0]];
        rdata_o = word_val[lane_bit +: 8];
    end

    assign mask_o = mask_q;

    for (genvar s = 0; s < int'(SRC_N); s++) begin : g_lvl
        assign lvl_o[s] = lvl_q[s/4][(s%4)*8 +: LVL_W];
    end

    // R1: reset values
    a_r1_reset_vals: assert property (@(posedge clk)
        rst |=> (stat_q == '1 && mask_q == '0 && lvl_q == '0));

    // R4: a sampled rise leaves its status bit at zero
    a_r4_rise_clears: assert property (@(posedge clk) disable iff (rst)
        (rise_i != '0) |=> ((stat_q & $past(rise_i)) == '0));

    // R3: a threshold write leaves the other lanes untouched
    a_r3_byte_only: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && word == W_MASK) |=>
        (((mask_q ^ $past(mask_q)) & ~(32'hFF << {$past(lane), 3'b000})) == '0));

    // R2: writes to the unmapped words change nothing
    a_r2_unmapped_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && (word == 3'd2 || word == 3'd3)) |=>
        ($stable(mask_q) && $stable(lvl_q)));

endmodule

// File: rtl/irqc_arb.sv
module irqc_arb
    import irqc_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic [SRC_N-1:0]             rise_i,
    input  logic [SRC_N-1:0]             fall_i,
    input  logic                         nmi_rise_i,
    input  logic                         nmi_fall_i,
    input  logic [SRC_N-1:0][LVL_W-1:0]  lvl_i,
    input  logic [WORD_W-1:0]            mask_i,
    output logic [CODE_W-1:0]            code_o,
    output logic                         vld_o
);
    logic [SRC_N-1:0] qual;
    irq_evt_t         ev;

    for (genvar s = 0; s < int'(SRC_N); s++) begin : g_qual
        assign qual[s] = rise_i[s] && (WORD_W'(lvl_i[s]) > mask_i);
    end

    always_comb begin
        ev.kind = EV_NONE;
        ev.src  = '0;
        for (int s = int'(SRC_N) - 1; s >= 0; s--) begin
            if (qual[s]) begin
                ev.kind = EV_SRC;
                ev.src  = 4'(s);
            end
        end
        if (nmi_rise_i)
            ev.kind = EV_NMI;
        else if (ev.kind == EV_NONE && (fall_i != '0 || nmi_fall_i))
            ev.kind = EV_CLR;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_o <= CODE_CLEAR;
            vld_o  <= 1'b0;
        end else begin
            vld_o <= (ev.kind != EV_NONE);
            if (ev.kind != EV_NONE) code_o <= code_of(ev);
        end
    end

    // R7: non-maskable rise always yields the fixed code
    a_r7_nmi_code: assert property (@(posedge clk) disable iff (rst)
        nmi_rise_i |=> (vld_o && code_o == CODE_NMI));

    // R9: a lone falling edge yields the clear code
    a_r9_clear_code: assert property (@(posedge clk) disable iff (rst)
        ((fall_i != '0 || nmi_fall_i) && !nmi_rise_i && rise_i == '0) |=>
        (vld_o && code_o == CODE_CLEAR));

    // R10: no edge, no strobe
    a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
        (rise_i == '0 && fall_i == '0 && !nmi_rise_i && !nmi_fall_i) |=> !vld_o);

    // R5: strobed codes stay in the legal set
    a_r5_code_range: assert property (@(posedge clk) disable iff (rst)
        vld_o |-> (code_o == CODE_CLEAR || code_o == CODE_NMI ||
                   code_o[5:4] == CODE_SRC_HI));

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irqc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [SRC_N-1:0]   src_i,
    input  logic               nmi_i,
    input  logic               bus_wr_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [BYTE_W-1:0]  bus_wdata_i,
    output logic [BYTE_W-1:0]  bus_rdata_o,
    output logic [CODE_W-1:0]  code_o,
    output logic               code_vld_o
);
    localparam int unsigned EW = SRC_N + 1;

    logic [EW-1:0]                rise_all, fall_all;
    logic [WORD_W-1:0]            mask_w;
    logic [SRC_N-1:0][LVL_W-1:0]  lvl_w;

    irqc_edge #(.W(EW)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .d_i    ({nmi_i, src_i}),
        .rise_o (rise_all),
        .fall_o (fall_all)
    );

    irqc_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en_i (bus_wr_i),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .rdata_o (bus_rdata_o),
        .rise_i  (rise_all[SRC_N-1:0]),
        .mask_o  (mask_w),
        .lvl_o   (lvl_w)
    );

    irqc_arb u_arb (
        .clk        (clk),
        .rst        (rst),
        .rise_i     (rise_all[SRC_N-1:0]),
        .fall_i     (fall_all[SRC_N-1:0]),
        .nmi_rise_i (rise_all[SRC_N]),
        .nmi_fall_i (fall_all[SRC_N]),
        .lvl_i      (lvl_w),
        .mask_i     (mask_w),
        .code_o     (code_o),
        .vld_o      (code_vld_o)
    );

endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] src;
    logic        nmi;
    logic        wr;
    logic [4:0]  addr;
    logic [7:0]  wdata;
    logic [7:0]  rdata;
    logic [5:0]  code;
    logic        vld;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference model state
    logic [15:0]      m_stat;
    logic [31:0]      m_mask;
    logic [3:0][31:0] m_lvl;
    logic [16:0]      m_prev;
    logic [5:0]       m_code;
    logic             m_vld;

    always #2.5 clk = ~clk;

    prio_irq_ctrl dut_i (
        .clk(clk), .rst(rst), .src_i(src), .nmi_i(nmi),
        .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .code_o(code), .code_vld_o(vld)
    );

    function automatic logic [7:0] m_read(logic [4:0] a);
        logic [31:0] w;
        case (a[4:2])
            3'd0: w = {16'h0, m_stat};
            3'd1: w = m_mask;
            3'd4, 3'd5, 3'd6, 3'd7: w = m_lvl[a[3:2]];
            default: w = 32'h0;
        endcase
        return w[{a[1:0], 3'b000} +: 8];
    endfunction

    function automatic logic [2:0] m_level(int s);
        return m_lvl[s/4][(s%4)*8 +: 3];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_stat = 16'hFFFF; m_mask = '0; m_lvl = '0;
        m_prev = '0; m_code = '0; m_vld = 1'b0;
    endtask

    // one clock cycle: drive, advance model, compare the strobe and code
    task automatic cyc(input logic [15:0] s, input logic n, input logic w,
                       input logic [4:0] a, input logic [7:0] d, input string req);
        logic [16:0] in, rise, fall;
        bit          hit;
        @(negedge clk);
        src = s; nmi = n; wr = w; addr = a; wdata = d;
        in = {n, s};
        rise = in & ~m_prev;
        fall = ~in & m_prev;
        hit = 1'b0;
        m_vld = 1'b0;
        if (rise[16]) begin
            m_vld = 1'b1; m_code = 6'd32;
        end else begin
            for (int i = 0; i < 16; i++) begin
                if (!hit && rise[i] && ({29'h0, m_level(i)} > m_mask)) begin
                    hit = 1'b1; m_vld = 1'b1; m_code = 6'(16 + i);
                end
            end
            if (!hit && fall != '0) begin
                m_vld = 1'b1; m_code = 6'd0;
            end
        end
        if (w) begin
            case (a[4:2])
                3'd0: if (a[1] == 1'b0) m_stat[{a[0], 3'b000} +: 8] = d;
                3'd1: m_mask[{a[1:0], 3'b000} +: 8] = d;
                3'd4, 3'd5, 3'd6, 3'd7: m_lvl[a[3:2]][{a[1:0], 3'b000} +: 8] = d;
                default: ;
            endcase
        end
        m_stat = m_stat & ~rise[15:0];
        m_prev = in;
        @(posedge clk);
        #1;
        check({req, " strobe"}, {31'h0, vld}, {31'h0, m_vld});
        check({req, " code"}, {26'h0, code}, {26'h0, m_code});
        wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input string req);
        addr = a;
        #0.5;
        check(req, {24'h0, rdata}, {24'h0, m_read(a)});
    endtask

    task automatic wbyte(input logic [4:0] a, input logic [7:0] d, input string req);
        cyc(src, nmi, 1'b1, a, d, req);
    endtask

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; src = '0; nmi = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 / R2: reset contents and unmapped reads
        check("R1 strobe", {31'h0, vld}, 32'h0);
        check("R1 code", {26'h0, code}, 32'h0);
        for (int a = 0; a < 32; a++) rd(5'(a), "R1_R2 reset read");

        // R3: single-lane writes
        wbyte(5'd5, 8'hA5, "R3 mask lane1");
        for (int a = 4; a < 8; a++) rd(5'(a), "R3 mask lanes");
        wbyte(5'd18, 8'h05, "R3 level lane2");
        for (int a = 16; a < 20; a++) rd(5'(a), "R3 level lanes");
        wbyte(5'd2, 8'h3C, "R3 status upper lane dropped");
        rd(5'd2, "R3 status upper reads zero");
        // R2: unmapped write discarded
        wbyte(5'd9, 8'hFF, "R2 unmapped write");
        rd(5'd9, "R2 unmapped read");
        for (int a = 4; a < 32; a++) rd(5'(a), "R2 no side effect");

        // R6 boundary: threshold 3, level of source 5 equal to 3
        wbyte(5'd5, 8'h00, "R6 setup");
        wbyte(5'd4, 8'h03, "R6 setup");
        wbyte(5'd21, 8'h03, "R6 setup");
        cyc(16'h0020, 1'b0, 1'b0, 5'd0, 8'h0, "R6 equal level gated");
        rd(5'd0, "R4 status bit5 cleared");
        cyc(16'h0000, 1'b0, 1'b0, 5'd0, 8'h0, "R9 fall clears");
        // R5: level one above threshold
        wbyte(5'd21, 8'h04, "R5 setup");
        cyc(16'h0020, 1'b0, 1'b0, 5'd0, 8'h0, "R5 forward code 21");
        cyc(16'h0020, 1'b0, 1'b0, 5'd0, 8'h0, "R10 held line no event");
        cyc(16'h0020, 1'b0, 1'b0, 5'd0, 8'h0, "R10 code held");
        cyc(16'h0000, 1'b0, 1'b0, 5'd0, 8'h0, "R9 fall after forward");

        // R7: non-maskable bypass with threshold at maximum, plus same-cycle source
        wbyte(5'd4, 8'hFF, "R7 setup");
        cyc(16'h0000, 1'b1, 1'b0, 5'd0, 8'h0, "R7 nmi code 32");
        cyc(16'h0000, 1'b0, 1'b0, 5'd0, 8'h0, "R9 nmi fall");
        wbyte(5'd4, 8'h00, "R7 setup");
        cyc(16'h0020, 1'b1, 1'b0, 5'd0, 8'h0, "R7 nmi over source");
        cyc(16'h0000, 1'b0, 1'b0, 5'd0, 8'h0, "R9 both fall");

        // R8: two qualifying sources rise together
        wbyte(5'd18, 8'h01, "R8 setup src2");
        wbyte(5'd25, 8'h01, "R8 setup src9");
        cyc(16'h0204, 1'b0, 1'b0, 5'd0, 8'h0, "R8 lowest wins code 18");
        cyc(16'h0000, 1'b0, 1'b0, 5'd0, 8'h0, "R9 fall");

        // R4: acknowledge by writing ones, and rise beating a same-cycle write
        wbyte(5'd0, 8'hFF, "R4 ack lane0");
        rd(5'd0, "R4 status lane0 after ack");
        cyc(16'h1000, 1'b0, 1'b1, 5'd1, 8'hFF, "R4 rise with write");
        rd(5'd1, "R4 rise beats write");
        cyc(16'h0000, 1'b0, 1'b0, 5'd0, 8'h0, "R9 fall");

        // R5 / R6 / R8 / R9 / R10: seeded random mix
        for (int it = 0; it < 4000; it++) begin
            logic [15:0] s;
            logic        n;
            logic        w;
            logic [4:0]  a;
            logic [7:0]  d;
            s = src;
            if ($urandom % 3 == 0) s[$urandom % 16] = ~s[$urandom % 16];
            if ($urandom % 5 == 0) s = s ^ 16'($urandom);
            n = ($urandom % 20 == 0) ? ~nmi : nmi;
            w = ($urandom % 3 == 0);
            a = 5'($urandom);
            d = 8'($urandom);
            if (a[4:2] == 3'd1) d = (a[1:0] == 2'd0) ? 8'($urandom % 8) : 8'h0;
            cyc(s, n, w, a, d, "R5_R6_R8_R9_R10 random");
            rd(5'($urandom), "R2 random read");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule